// File: doc/BRIEF.md
# Hot-Loop Fetch Bypass

This block sits between a processor core's instruction fetch and its program ROM. It keeps a small local copy of one frequently executed loop and feeds the core from that copy while execution stays inside the loop. The ROM is then left disabled, which saves power. The loop to hold is described in a few words of configuration memory. Every reset starts a load sequence with three steps:

- read the loop's first and last addresses;
- copy the loop body from ROM into the local table;
- only after the copy, arm the bypass.

During the copy, each table entry is given a marker bit that flags the loop's closing byte. After that closing byte, the bypass decides whether to stay in the table or leave it by checking only whether the next fetch returns to the loop head. It needs no tag lookup and has no miss path.

The core sees the same byte stream, with the same timing, whether a byte comes from ROM or from the table. Requests use a valid/ready handshake:

- Ready (`fetch_ready`) stays low until the load sequence has finished.
- After that, every request is accepted in the cycle it is presented.
- The response comes back exactly one cycle later.
- The response has no back-pressure: the core must take each response in the cycle it appears.

Top module: `loop_fetch_bypass`

## Requirements
- R1: While reset is held, and until the load sequence completes, `fetch_ready`, `rsp_valid` and `bypass_on` are low. `fill_done` stays high from the moment it first rises until the next reset.
- R2: Configuration word 0 bit 0 means a loop is stored. Word 1 holds the loop's first byte address and word 2 holds its last byte address, inclusive. An accepted loop is copied by reading each of its bytes from ROM exactly once, so the number of ROM enables during the load equals the loop length.
- R3: With word 0 bit 0 clear, no ROM read is made during the load, `bypass_on` stays low, and every fetch enables the ROM.
- R4: A loop whose length exceeds DEPTH bytes, or whose last address is below its first, is rejected: no copy, and `bypass_on` stays low. A loop of exactly DEPTH bytes is accepted.
- R5: The table is entered only by a fetch of the loop's first address. A fetch inside the loop range that was not reached from the first address goes to ROM.
- R6: Once the table is entered, every fetch that stays inside the loop range is served from the table, and `rom_en` is low in that cycle. A cycle with no request does not leave the table.
- R7: After the loop's last byte is served, a fetch of the first address stays in the table. Any other address leaves it, and `rom_en` is high in that same cycle.
- R8: A fetch outside the loop range, made while the table is serving, asserts `rom_en` in the same cycle.
- R9: Each accepted request produces `rsp_valid` exactly one cycle later. The data equals the ROM byte at that address, whether it came from ROM or from the table, and back-to-back requests see no stall.
- R10: `bypass_on` rises only when `fill_done` is already high, or rises together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the load sequence |
| cfg_addr | output | CFG_AW | Configuration word index (combinational read) |
| cfg_data | input | ADDR_W | Configuration word at `cfg_addr` |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_data | input | DATA_W | ROM byte, one cycle after the enable |
| fetch_valid | input | 1 | Core presents a fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | Requests are accepted (high after the load) |
| rsp_valid | output | 1 | Response byte valid, one cycle after acceptance |
| rsp_data | output | DATA_W | Instruction byte |
| fill_done | output | 1 | Load sequence complete |
| bypass_on | output | 1 | A loop is held and the table may serve fetches |

## Verification
The bench uses the defaults: ADDR_W 16, DATA_W 8, DEPTH 64 and CFG_AW 2. With DEPTH at 64, both sides of the length limit can be reached. A 64-byte loop runs through every table index and the marker on the final entry. A 65-byte loop is rejected. A 16-bit address gives room for loops far apart, and for fetches out of range on either side. Loads that find no loop, and loads that are rejected, show the ROM-only path after a fresh reset.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [2:0] {
    LD_FLAG,
    LD_START,
    LD_END,
    LD_COPY,
    LD_DONE
  } ld_state_e;
endpackage

// File: rtl/lfb_loader.sv
module lfb_loader
  import lfb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64,
  parameter int CFG_AW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [CFG_AW-1:0]         cfg_addr,
  input  logic [ADDR_W-1:0]         cfg_data,
  output logic                      rom_en,
  output logic [ADDR_W-1:0]         rom_addr,
  output logic [ADDR_W-1:0]         loop_start,
  output logic [$clog2(DEPTH)-1:0]  loop_last,
  output logic                      wr_en,
  output logic [$clog2(DEPTH)-1:0]  wr_idx,
  output logic                      fill_done,
  output logic                      loop_en
);
  localparam int IDX_W = $clog2(DEPTH);

  ld_state_e          state;
  logic [ADDR_W-1:0]  start_q;
  logic [IDX_W-1:0]   last_q;
  logic [IDX_W:0]     iss;
  logic               wr_en_q;
  logic [IDX_W-1:0]   wr_idx_q;
  logic               done_q, en_q;
  logic [ADDR_W-1:0]  span;
  logic               issue;

  assign span  = cfg_data - start_q;
  assign issue = (state == LD_COPY) && (iss <= {1'b0, last_q});

  always_comb begin
    case (state)
      LD_START: cfg_addr = CFG_AW'(1);
      LD_END:   cfg_addr = CFG_AW'(2);
      default:  cfg_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LD_FLAG;
      start_q  <= '0;
      last_q   <= '0;
      iss      <= '0;
      wr_en_q  <= 1'b0;
      wr_idx_q <= '0;
      done_q   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      wr_en_q  <= issue;
      wr_idx_q <= iss[IDX_W-1:0];
      if (issue) iss <= iss + 1'b1;
      case (state)
        LD_FLAG: begin
          if (cfg_data[0]) state <= LD_START;
          else begin
            state  <= LD_DONE;
            done_q <= 1'b1;
          end
        end
        LD_START: begin
          start_q <= cfg_data;
          state   <= LD_END;
        end
        LD_END: begin
          if ((cfg_data < start_q) || (span >= ADDR_W'(DEPTH))) begin
            state  <= LD_DONE;
            done_q <= 1'b1;
          end else begin
            last_q <= span[IDX_W-1:0];
            state  <= LD_COPY;
          end
        end
        LD_COPY: begin
          if (wr_en_q && (wr_idx_q == last_q)) begin
            state  <= LD_DONE;
            done_q <= 1'b1;
            en_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign rom_en     = issue;
  assign rom_addr   = start_q + {{(ADDR_W-IDX_W-1){1'b0}}, iss};
  assign loop_start = start_q;
  assign loop_last  = last_q;
  assign wr_en      = wr_en_q;
  assign wr_idx     = wr_idx_q;
  assign fill_done  = done_q;
  assign loop_en    = en_q;

  assert_en_after_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> fill_done);
  assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> fill_done);
  assert_no_read_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> !fill_done);
endmodule

// File: rtl/lfb_store.sv
module lfb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      wr_exit,
  input  logic                      rd_en,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_exit
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem    [DEPTH];
  logic              exit_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) mem[i] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) exit_q[i] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(i))) exit_q[i] <= wr_exit;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_data = rd_q;
  assign rd_exit = exit_q[rd_idx];

  assert_no_read_during_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_en);
endmodule

// File: rtl/lfb_bypass.sv
module lfb_bypass #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      loop_en,
  input  logic [ADDR_W-1:0]         loop_start,
  input  logic [$clog2(DEPTH)-1:0]  loop_last,
  input  logic                      req,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      entry_exit,
  output logic                      hit,
  output logic [$clog2(DEPTH)-1:0]  idx
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] off;
  logic              in_range, at_start;
  logic              serving, after_exit;

  assign off      = req_addr - loop_start;
  assign idx      = off[IDX_W-1:0];
  assign at_start = (off == '0);
  assign in_range = (off <= {{(ADDR_W-IDX_W){1'b0}}, loop_last});
  assign hit      = loop_en && req && (at_start || (serving && !after_exit && in_range));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serving    <= 1'b0;
      after_exit <= 1'b0;
    end else if (req) begin
      serving    <= hit;
      after_exit <= hit && entry_exit;
    end
  end

  assert_serving_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> loop_en);
  assert_idle_holds_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(serving));
endmodule

// File: rtl/loop_fetch_bypass.sv
module loop_fetch_bypass #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_done,
  output logic              bypass_on
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              ld_rom_en;
  logic [ADDR_W-1:0] ld_rom_addr;
  logic [ADDR_W-1:0] loop_start;
  logic [IDX_W-1:0]  loop_last;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              loop_en;
  logic              accept, hit, entry_exit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] tbl_data;
  logic              rsp_q, from_tbl_q;

  lfb_loader #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CFG_AW(CFG_AW)) u_loader (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rom_en(ld_rom_en), .rom_addr(ld_rom_addr), .loop_start(loop_start),
    .loop_last(loop_last), .wr_en(wr_en), .wr_idx(wr_idx),
    .fill_done(fill_done), .loop_en(loop_en)
  );

  lfb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(rom_data), .wr_exit(wr_idx == loop_last),
    .rd_en(hit), .rd_idx(idx), .rd_data(tbl_data), .rd_exit(entry_exit)
  );

  lfb_bypass #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_bypass (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .loop_start(loop_start),
    .loop_last(loop_last), .req(accept), .req_addr(fetch_addr),
    .entry_exit(entry_exit), .hit(hit), .idx(idx)
  );

  assign fetch_ready = fill_done;
  assign accept      = fetch_valid && fill_done;
  assign rom_en      = fill_done ? (accept && !hit) : ld_rom_en;
  assign rom_addr    = fill_done ? fetch_addr : ld_rom_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q      <= 1'b0;
      from_tbl_q <= 1'b0;
    end else begin
      rsp_q      <= accept;
      from_tbl_q <= hit;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_data  = from_tbl_q ? tbl_data : rom_data;
  assign bypass_on = loop_en;

  assert_rsp_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> rsp_valid);
  assert_rom_off_only_in_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && fetch_valid && !rom_en) |-> bypass_on);
  assert_no_ready_before_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |-> !fetch_ready);
endmodule

// File: tb/test_loop_fetch_bypass.sv
module test_loop_fetch_bypass;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam int CFG_AW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CFG_AW-1:0] cfg_addr;
  logic [ADDR_W-1:0] cfg_data;
  logic              rom_en;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data = '0;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              fetch_ready, rsp_valid, fill_done, bypass_on;
  logic [DATA_W-1:0] rsp_data;

  logic [ADDR_W-1:0] cfg_mem [4];
  int n_chk = 0, n_bad = 0, cyc = 0, fill_cnt = 0;
  int exp_addr_q[$];
  int exp_cyc_q[$];

  always #10 clk = ~clk;

  loop_fetch_bypass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CFG_AW(CFG_AW)) i_loop_fetch_bypass (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fill_done(fill_done), .bypass_on(bypass_on)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign cfg_data = cfg_mem[cfg_addr];
  always @(posedge clk) if (rom_en) rom_data <= rom_byte(rom_addr);
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && !fill_done && rom_en) fill_cnt++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard, checks data and one-cycle latency (R9)
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_addr_q.size() == 0) chk(1'b0, "R9", "unexpected response", 1, 0);
      else begin
        int a, c;
        a = exp_addr_q.pop_front();
        c = exp_cyc_q.pop_front();
        chk(cyc == c + 1, "R9", "response latency", cyc - c, 1);
        chk(rsp_data == rom_byte(a[15:0]), "R9", "response data", rsp_data, rom_byte(a[15:0]));
      end
    end
  end

  task automatic fetch(input logic [15:0] a, input logic exp_rom, input string req);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    exp_addr_q.push_back(int'(a));
    exp_cyc_q.push_back(cyc);
    #1;
    chk(rom_en == exp_rom, req, $sformatf("rom_en at %0h", a), rom_en, exp_rom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_valid = 1'b0;
    end
  endtask

  task automatic load(input logic flag, input logic [15:0] first, input logic [15:0] last,
                      input logic exp_on, input int exp_len, input string req);
    idle(2);
    rst_n = 1'b0;
    cfg_mem[0] = {15'd0, flag};
    cfg_mem[1] = first;
    cfg_mem[2] = last;
    cfg_mem[3] = '0;
    repeat (3) @(negedge clk);
    fill_cnt = 0;
    chk(!fetch_ready && !rsp_valid && !bypass_on, "R1", "outputs in reset", 1, 0);
    rst_n = 1'b1;
    #1;
    chk(!fetch_ready, "R1", "ready right after reset", fetch_ready, 0);
    for (int i = 0; i < 300 && !fill_done; i++) begin
      @(negedge clk);
      chk(!(bypass_on && !fill_done), "R10", "bypass before fill", bypass_on, 0);
      if (!fill_done) chk(!fetch_ready, "R1", "ready during fill", fetch_ready, 0);
    end
    chk(fill_done, "R1", "fill_done", fill_done, 1);
    chk(bypass_on == exp_on, req, "bypass_on", bypass_on, exp_on);
    chk(fill_cnt == exp_len, "R2", "rom reads during load", fill_cnt, exp_len);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    // 16-byte loop at 0x0100..0x010F
    load(1'b1, 16'h0100, 16'h010F, 1'b1, 16, "R2");
    fetch(16'h00FE, 1'b1, "R8");
    fetch(16'h00FF, 1'b1, "R8");
    fetch(16'h0104, 1'b1, "R5");              // inside range, not entered at head
    fetch(16'h0105, 1'b1, "R5");
    for (int a = 16'h0100; a <= 16'h010F; a++) fetch(a[15:0], 1'b0, "R6");
    fetch(16'h0100, 1'b0, "R7");              // back to head after last byte
    fetch(16'h0101, 1'b0, "R6");
    idle(1);                                   // no request: stays in table
    fetch(16'h0102, 1'b0, "R6");
    fetch(16'h010F, 1'b0, "R6");              // jump within range
    fetch(16'h0105, 1'b1, "R7");              // after last byte, not head
    fetch(16'h0106, 1'b1, "R7");
    fetch(16'h0100, 1'b0, "R6");
    fetch(16'h0101, 1'b0, "R6");
    fetch(16'h0300, 1'b1, "R8");              // out of range above
    fetch(16'h0102, 1'b1, "R8");
    fetch(16'h0100, 1'b0, "R6");
    fetch(16'h00F0, 1'b1, "R8");              // out of range below
    idle(2);
    chk(exp_addr_q.size() == 0, "R9", "pending responses", exp_addr_q.size(), 0);

    // No loop stored
    load(1'b0, 16'h0100, 16'h010F, 1'b0, 0, "R3");
    fetch(16'h0100, 1'b1, "R3");
    fetch(16'h0101, 1'b1, "R3");

    // 65 bytes: rejected
    load(1'b1, 16'h0200, 16'h0240, 1'b0, 0, "R4");
    fetch(16'h0200, 1'b1, "R4");
    fetch(16'h0201, 1'b1, "R4");

    // last below first: rejected
    load(1'b1, 16'h0300, 16'h02FF, 1'b0, 0, "R4");
    fetch(16'h0300, 1'b1, "R4");

    // exactly DEPTH bytes: accepted
    load(1'b1, 16'h0231, 16'h0270, 1'b1, 64, "R4");
    for (int a = 16'h0231; a <= 16'h0270; a++) fetch(a[15:0], 1'b0, "R4");
    fetch(16'h0231, 1'b0, "R7");
    fetch(16'h0232, 1'b0, "R6");
    fetch(16'h0271, 1'b1, "R8");
    idle(2);
    chk(exp_addr_q.size() == 0, "R9", "pending responses", exp_addr_q.size(), 0);
    finish_up();
  end
endmodule